// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt pins and turns each into a per-pin interrupt line toward a parent interrupt controller. Every pin has its own detection mode, a latched request bit, a mask bit and a priority field. Software programs and inspects the block through five word-wide registers on a simple synchronous bus, where each read or write takes one cycle.

Each pin first passes through a two-flop synchroniser. Edge modes latch a request that software clears by writing zeros to the source register. Level modes make the request follow the pin's level while it is active. A pin's output line is asserted when its request is pending, its mask is clear and its priority field is nonzero. Masks are changed only through two write-only registers, one that sets mask bits and one that clears them, so no read-modify-write is needed.

Register addresses: 0 sense, 1 priority, 2 source, 3 mask-set, 4 mask-clear. Read data appears on `bus_rdata` one cycle after `bus_rd`.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset the sense, priority and source registers read 0, every mask bit is set, and no output line is asserted, even when a request is later latched before any mask is cleared.
- R2: The sense register is read-write. Pin n's field is SENSE_W bits wide (4 by default) at bit offset (NUM_PINS-1-n)*SENSE_W.
- R3: Sense code 1 latches pin n's request on a rising edge of the synchronised pin, and code 0 latches it on a falling edge. The request stays set after the pin returns to its previous level.
- R4: Sense code 2 (low level) and code 3 (high level) make the request follow the active level. Writing 0 to the request while the level is still active leaves it set, and the request drops when the level goes inactive.
- R5: Sense code 4 latches the request on both rising and falling edges.
- R6: Sense codes 5 and above never set a request.
- R7: The source register reads pin n's request at bit NUM_PINS-1-n, so pin 0 is bit 7 by default. The upper bits read 0.
- R8: A write to the source register clears each request bit written as 0 and leaves each bit written as 1 unchanged.
- R9: A write to the mask-set register (address 3) sets pin n's mask where data bit NUM_PINS-1-n is 1. Zero bits have no effect.
- R10: A write to the mask-clear register (address 4) clears pin n's mask where data bit NUM_PINS-1-n is 1. Zero bits have no effect. Reads of addresses 3 and 4 return 0.
- R11: Output irq_out[n] is registered. It is 1 exactly when, in the cycle before, pin n's request was set, its mask was clear and its priority field was nonzero.
- R12: The priority register is read-write with a PRIO_W-bit field (4 by default) for pin n at offset (NUM_PINS-1-n)*PRIO_W. A field of 0 keeps irq_out[n] low while the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins, bit n is pin n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| irq_out | output | NUM_PINS | Per-pin interrupt lines, bit n is pin n |

## Verification
Some behaviours are checked by the embedded properties on every cycle. These are:
- a set mask or a zero priority field forces the output low on the next cycle;
- an output is never raised without a pending request;
- an armed rising edge always latches a request;
- a high-level pin's request tracks its synchronised level;
- a disabled sense code never creates a request;
- mask-set writes take effect;
- the write-only addresses read as zero.

Other behaviours only the bench's scenarios can show:
- the MSB-first bit placement in the sense, priority, source and mask registers;
- that a cleared level request comes back while the level persists;
- that both-edge mode fires in each direction;
- that write-zero-to-clear leaves the bits written as 1 alone;
- the order in which a pin change reaches the output through the synchroniser.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  // register addresses
  localparam int ADDR_SENSE = 0;
  localparam int ADDR_PRIO  = 1;
  localparam int ADDR_SRC   = 2;
  localparam int ADDR_MSET  = 3;
  localparam int ADDR_MCLR  = 4;

  // sense codes (widened to 4 bits before decoding)
  localparam logic [3:0] SNS_FALL = 4'd0;
  localparam logic [3:0] SNS_RISE = 4'd1;
  localparam logic [3:0] SNS_LOW  = 4'd2;
  localparam logic [3:0] SNS_HIGH = 4'd3;
  localparam logic [3:0] SNS_BOTH = 4'd4;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] async_in,
  output logic [NUM_PINS-1:0] sync_out
);
  logic [NUM_PINS-1:0] stage1_q;
  logic [NUM_PINS-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
  import pinirq_pkg::*;
#(
  parameter int SENSE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lvl,      // synchronised pin level
  input  logic [SENSE_W-1:0] mode,
  input  logic               clr_req,  // write-zero clear for this pin
  output logic               req
);
  logic       prev_q;
  logic       req_q;
  logic [3:0] code;
  logic       rise, fall, is_level, level_on, edge_hit;

  always_comb begin
    code     = 4'(mode);
    rise     = lvl & ~prev_q;
    fall     = ~lvl & prev_q;
    is_level = 1'b0;
    level_on = 1'b0;
    edge_hit = 1'b0;
    case (code)
      SNS_FALL: edge_hit = fall;
      SNS_RISE: edge_hit = rise;
      SNS_LOW:  begin is_level = 1'b1; level_on = ~lvl; end
      SNS_HIGH: begin is_level = 1'b1; level_on = lvl;  end
      SNS_BOTH: edge_hit = rise | fall;
      default:  edge_hit = 1'b0;   // disabled codes
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (is_level)      req_q <= level_on;
      else if (edge_hit) req_q <= 1'b1;
      else if (clr_req)  req_q <= 1'b0;
    end
  end

  assign req = req_q;

  // R3: an armed rising edge always latches the request
  p_rise_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (code == SNS_RISE && lvl && !prev_q) |=> req_q);

  // R4: high-level mode follows the synchronised level
  p_high_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (code == SNS_HIGH) |=> (req_q == $past(lvl)));

  // R6: disabled codes never create a request
  p_disabled_no_set_r6: assert property (@(posedge clk) disable iff (rst)
    (code >= 4'd5 && !req_q) |=> !req_q);
endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
  import pinirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int PRIO_W   = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [NUM_PINS-1:0]          src_packed,  // MSB-first request view
  output logic [NUM_PINS*SENSE_W-1:0]  sense_flat,
  output logic [NUM_PINS*PRIO_W-1:0]   prio_flat,
  output logic [NUM_PINS-1:0]          mask,        // pin-indexed
  output logic [NUM_PINS-1:0]          src_clr      // pin-indexed
);
  localparam int SENSE_BITS = NUM_PINS * SENSE_W;
  localparam int PRIO_BITS  = NUM_PINS * PRIO_W;

  logic [SENSE_BITS-1:0] sense_q;
  logic [PRIO_BITS-1:0]  prio_q;
  logic [NUM_PINS-1:0]   mask_q;
  logic [DATA_W-1:0]     rdata_q;
  logic                  wr_sense, wr_prio, wr_src, wr_mset, wr_mclr;

  always_comb begin
    wr_sense = bus_wr && (int'(bus_addr) == ADDR_SENSE);
    wr_prio  = bus_wr && (int'(bus_addr) == ADDR_PRIO);
    wr_src   = bus_wr && (int'(bus_addr) == ADDR_SRC);
    wr_mset  = bus_wr && (int'(bus_addr) == ADDR_MSET);
    wr_mclr  = bus_wr && (int'(bus_addr) == ADDR_MCLR);
  end

  generate
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      localparam int BITPOS = NUM_PINS - 1 - n;

      assign src_clr[n] = wr_src && !bus_wdata[BITPOS];

      always_ff @(posedge clk) begin
        if (rst)                               mask_q[n] <= 1'b1;
        else if (wr_mset && bus_wdata[BITPOS]) mask_q[n] <= 1'b1;
        else if (wr_mclr && bus_wdata[BITPOS]) mask_q[n] <= 1'b0;
      end

      // R9: a 1 written to mask-set masks the pin
      p_mset_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_mset && bus_wdata[BITPOS]) |=> mask_q[n]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      prio_q  <= '0;
    end else begin
      if (wr_sense) sense_q <= bus_wdata[SENSE_BITS-1:0];
      if (wr_prio)  prio_q  <= bus_wdata[PRIO_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (int'(bus_addr))
        ADDR_SENSE: rdata_q <= DATA_W'(sense_q);
        ADDR_PRIO:  rdata_q <= DATA_W'(prio_q);
        ADDR_SRC:   rdata_q <= DATA_W'(src_packed);
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign sense_flat = sense_q;
  assign prio_flat  = prio_q;
  assign mask       = mask_q;
  assign bus_rdata  = rdata_q;

  // R10: write-only addresses read as zero
  p_wo_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (int'(bus_addr) == ADDR_MSET || int'(bus_addr) == ADDR_MCLR))
      |=> (rdata_q == '0));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pinirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int PRIO_W   = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] irq_out
);
  logic [NUM_PINS-1:0]         pin_s;
  logic [NUM_PINS-1:0]         req;
  logic [NUM_PINS-1:0]         src_packed;
  logic [NUM_PINS-1:0]         mask;
  logic [NUM_PINS-1:0]         src_clr;
  logic [NUM_PINS*SENSE_W-1:0] sense_flat;
  logic [NUM_PINS*PRIO_W-1:0]  prio_flat;
  logic [NUM_PINS-1:0]         irq_q;

  pinirq_sync #(.NUM_PINS(NUM_PINS)) i_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_s)
  );

  pinirq_regs #(
    .NUM_PINS(NUM_PINS), .SENSE_W(SENSE_W), .PRIO_W(PRIO_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_packed(src_packed), .sense_flat(sense_flat),
    .prio_flat(prio_flat), .mask(mask), .src_clr(src_clr)
  );

  generate
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      localparam int SLOT = NUM_PINS - 1 - n;
      logic [SENSE_W-1:0] mode;
      logic [PRIO_W-1:0]  prio;
      logic               prio_on;

      assign mode    = sense_flat[SLOT*SENSE_W +: SENSE_W];
      assign prio    = prio_flat[SLOT*PRIO_W +: PRIO_W];
      assign prio_on = |prio;
      assign src_packed[SLOT] = req[n];

      pinirq_detect #(.SENSE_W(SENSE_W)) i_detect (
        .clk(clk), .rst(rst), .lvl(pin_s[n]), .mode(mode),
        .clr_req(src_clr[n]), .req(req[n])
      );

      always_ff @(posedge clk) begin
        if (rst) irq_q[n] <= 1'b0;
        else     irq_q[n] <= req[n] & ~mask[n] & prio_on;
      end

      // R11: a set mask keeps the line low on the next cycle
      p_mask_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        mask[n] |=> !irq_q[n]);
      // R11: no line without a pending request
      p_needs_req_r11: assert property (@(posedge clk) disable iff (rst)
        irq_q[n] |-> $past(req[n]));
      // R12: a zero priority field blocks the line
      p_prio_zero_r12: assert property (@(posedge clk) disable iff (rst)
        !prio_on |=> !irq_q[n]);
    end
  endgenerate

  assign irq_out = irq_q;
endmodule

// File: tb/test_pin_irq_ctrl.sv
`timescale 1ns/1ps
module test_pin_irq_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] pin_in = 8'h86;   // pins 1,2,7 idle high
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_out;

  int checks = 0;
  int fails  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  pin_irq_ctrl i_pin_irq_ctrl (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual %08h expected %08h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'(addr);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq_out !== exp) begin
      fails++;
      $display("FAIL %s: irq_out actual %02h expected %02h", tag, irq_out, exp);
    end
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    pin_in[n] = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_irq(8'h00, "R1 reset irq");
    rd(0, 32'h0, "R1 reset sense");
    rd(1, 32'h0, "R1 reset prio");
    rd(2, 32'h0, "R1 reset source");

    // pin0 rise, pin1 fall, pin2 low, pin3 high, pin4 both, pin5 code5, pin6 rise, pin7 fall
    wr(0, 32'h1023_4510);
    rd(0, 32'h1023_4510, "R2 sense layout");
    wr(1, 32'hFFFF_FFF0);
    rd(1, 32'hFFFF_FFF0, "R12 prio readback");

    set_pin(0, 1'b1);
    rd(2, 32'h80, "R3 rise latch, R7 pin0 at bit7");
    chk_irq(8'h00, "R1 masks set after reset");

    wr(4, 32'hFF);
    rd(4, 32'h0, "R10 mask-clear reads zero");
    rd(3, 32'h0, "R10 mask-set reads zero");
    chk_irq(8'h01, "R11 unmasked pin0");

    set_pin(1, 1'b0);
    rd(2, 32'hC0, "R3 fall latch");
    set_pin(1, 1'b1);
    rd(2, 32'hC0, "R3 request held after pin returns");

    set_pin(2, 1'b0);
    rd(2, 32'hE0, "R4 low level active");
    wr(2, 32'hDF);
    rd(2, 32'hE0, "R4 clear while level active");
    set_pin(2, 1'b1);
    rd(2, 32'hC0, "R4 low level released");

    set_pin(3, 1'b1);
    rd(2, 32'hD0, "R4 high level active");
    set_pin(3, 1'b0);
    rd(2, 32'hC0, "R4 high level released");

    set_pin(4, 1'b1);
    rd(2, 32'hC8, "R5 both-edge rising");
    wr(2, 32'hF7);
    rd(2, 32'hC0, "R8 clear pin4 only");
    set_pin(4, 1'b0);
    rd(2, 32'hC8, "R5 both-edge falling");

    set_pin(5, 1'b1);
    set_pin(5, 1'b0);
    rd(2, 32'hC8, "R6 code5 disabled");

    wr(2, 32'h7F);
    rd(2, 32'h48, "R8 clear pin0, others kept");
    chk_irq(8'h12, "R11 pins 1 and 4");

    wr(3, 32'h08);
    chk_irq(8'h02, "R9 mask-set pin4 only");

    set_pin(7, 1'b0);
    rd(2, 32'h49, "R7 pin7 at bit0");
    chk_irq(8'h02, "R12 zero prio blocks pin7");
    wr(1, 32'hFFFF_FFF1);
    chk_irq(8'h82, "R12 nonzero prio passes pin7");

    wr(4, 32'h00);
    chk_irq(8'h82, "R10 zero mask-clear no effect");
    wr(4, 32'h08);
    chk_irq(8'h92, "R10 mask-clear pin4");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule